// File: doc/BRIEF.md
# Per-Line GPIO Register Bank

This block is a memory-mapped general-purpose I/O controller in which every I/O line owns a byte-wide control register. Each register shows the line's synchronized input level. It also holds the value the line drives and an active-high output-disable control. A simple synchronous register port (address, write strobe, write byte, read byte) reaches the registers. The lines are placed sparsely inside a 512-byte window that could hold 128 lines, and only 32 of those slots are populated.

Software sets a line's direction and level by writing its byte. It reads the pin back through bit 0 of the same byte. Pad inputs pass through a two-stage synchronizer before software or the interrupt outputs can see them. The four lines of the highest group are also forwarded, as synchronized levels, to a parent interrupt controller. That controller does the edge detection and masking for them. Output `irq_lvl[k]` feeds parent interrupt number 28 + k, and it carries the line at byte offset 0x1C0 + 4·k.

Top module: `pinbank_ctrl`

## Requirements
- R1: Populated lines sit at word-aligned byte offsets, 4 bytes apart inside a group. There are five groups: 0x050 (4 lines, line indices 0-3), 0x088 (16 lines, 4-19), 0x140 (6 lines, 20-25), 0x188 (2 lines, 26-27) and 0x1C0 (4 lines, 28-31). Line index i drives bit i of `pad_out` and `pad_oe` and reads bit i of `pad_in`.
- R2: Bit 0 of a line's register is read-only. It returns that line's `pad_in` level after a two-flop synchronizer.
- R3: Bit 4 of a line's register holds the output value, and `pad_out[i]` always carries it.
- R4: Bit 5 of a line's register is an output disable. When it is 1, `pad_oe[i]` is 0. When it is 0, `pad_oe[i]` is 1 and the pad drives the bit 4 value. Bits 4 and 5 read back as written.
- R5: After reset every line has bit 5 = 1 and bit 4 = 0. So `pad_oe` and `pad_out` are all zero, and a populated register reads 0x20 with the input level in bit 0.
- R6: A read of an unpopulated or non-word-aligned offset returns 0x00. A write to one changes no line.
- R7: Register bits 1, 2, 3, 6 and 7 always read 0. Writing bit 0 has no effect.
- R8: `bus_rdata` shows the register selected by `bus_addr` one clock after the address is presented, and it holds until the next clock edge. A write changes `pad_out`/`pad_oe` on the clock edge that samples `bus_we`. No other event changes them except reset.
- R9: `irq_lvl[k]` equals the synchronized level of line 28 + k (offset 0x1C0 + 4·k, parent interrupt 28 + k). It follows `pad_in` with exactly two clock edges of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 9 | Byte offset into the register window |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| pad_in | input | 32 | Pad input level per line |
| pad_out | output | 32 | Pad output value per line |
| pad_oe | output | 32 | Pad output enable per line, active high |
| irq_lvl | output | 4 | Synchronized levels to parent interrupts 28 to 31 |

## Verification
A wrong line cell shows up on the next clock edge, because the cell's bit of `pad_out` or `pad_oe` differs from the value just written. It also appears in the byte read back one clock later. A decode fault that aliases an unpopulated or misaligned offset onto a line becomes visible as a pad change on the edge of the stray write, or as a nonzero read of a hole. A wrong synchronizer depth shows as `irq_lvl` or bit 0 changing one edge early or late after a `pad_in` step.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int unsigned ADDR_W  = 9;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned NUM_GRP = 5;

    typedef int unsigned grp_tbl_t [NUM_GRP];

    // sparse line map: byte offset of each group's first line and its length
    localparam grp_tbl_t GRP_BASE = '{32'h050, 32'h088, 32'h140, 32'h188, 32'h1c0};
    localparam grp_tbl_t GRP_LEN  = '{32'd4, 32'd16, 32'd6, 32'd2, 32'd4};

    function automatic int unsigned grp_first(int unsigned g);
        int unsigned acc;
        acc = 0;
        for (int unsigned k = 0; k < NUM_GRP; k++) begin
            if (k < g) acc += GRP_LEN[k];
        end
        return acc;
    endfunction

    localparam int unsigned NUM_LINES = grp_first(NUM_GRP);
    localparam int unsigned LINE_W    = $clog2(NUM_LINES);

    // group whose lines are forwarded to the parent interrupt controller
    localparam int unsigned IRQ_GRP   = NUM_GRP - 1;
    localparam int unsigned IRQ_FIRST = grp_first(IRQ_GRP);
    localparam int unsigned IRQ_CNT   = GRP_LEN[IRQ_GRP];

    localparam int unsigned BIT_LVL = 0;
    localparam int unsigned BIT_VAL = 4;
    localparam int unsigned BIT_DIS = 5;

    typedef struct packed {
        logic dis;
        logic val;
    } line_ctl_t;

    localparam line_ctl_t CTL_RESET = '{dis: 1'b1, val: 1'b0};

    typedef struct packed {
        logic              hit;
        logic [LINE_W-1:0] idx;
    } line_sel_t;

    function automatic logic [DATA_W-1:0] pack_reg(logic lvl, line_ctl_t c);
        logic [DATA_W-1:0] r;
        r          = '0;
        r[BIT_LVL] = lvl;
        r[BIT_VAL] = c.val;
        r[BIT_DIS] = c.dis;
        return r;
    endfunction

    function automatic line_ctl_t unpack_reg(logic [DATA_W-1:0] d);
        line_ctl_t c;
        c.dis = d[BIT_DIS];
        c.val = d[BIT_VAL];
        return c;
    endfunction

    // behavioural lookup, used by the checker
    function automatic line_sel_t lookup(logic [ADDR_W-1:0] a);
        line_sel_t   s;
        int unsigned w;
        s = '0;
        w = 32'(a[ADDR_W-1:2]);
        if (a[1:0] == 2'b00) begin
            for (int unsigned g = 0; g < NUM_GRP; g++) begin
                if (w >= GRP_BASE[g] / 4 && w < GRP_BASE[g] / 4 + GRP_LEN[g]) begin
                    s.hit = 1'b1;
                    s.idx = LINE_W'(grp_first(g) + w - GRP_BASE[g] / 4);
                end
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
    import pinbank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output line_sel_t         sel
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0]  word;
    logic               aligned;
    logic [NUM_GRP-1:0] grp_hit;
    logic [LINE_W-1:0]  grp_idx [NUM_GRP];

    assign word    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam int unsigned W_LO  = GRP_BASE[g] / 4;
        localparam int unsigned W_TOP = W_LO + GRP_LEN[g] - 1;
        localparam int unsigned FIRST = grp_first(g);

        assign grp_hit[g] = aligned
                          && (word >= WORD_W'(W_LO))
                          && (word <= WORD_W'(W_TOP));
        assign grp_idx[g] = grp_hit[g]
                          ? LINE_W'(word - WORD_W'(W_LO) + WORD_W'(FIRST))
                          : '0;
    end

    // groups are disjoint, so an OR merge is enough
    always_comb begin
        sel.hit = |grp_hit;
        sel.idx = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            sel.idx = sel.idx | grp_idx[g];
        end
    end

endmodule

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= '0;
                else     chain[0] <= d;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) chain[s] <= '0;
                else     chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pinbank_cell.sv
module pinbank_cell
    import pinbank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  line_ctl_t wr_ctl,
    output line_ctl_t ctl,
    output logic      pad_o,
    output logic      pad_en
);
    always_ff @(posedge clk) begin
        if (rst)        ctl <= CTL_RESET;
        else if (wr_en) ctl <= wr_ctl;
    end

    assign pad_o  = ctl.val;
    assign pad_en = ~ctl.dis;

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_LINES-1:0] pad_in,
    output logic [NUM_LINES-1:0] pad_out,
    output logic [NUM_LINES-1:0] pad_oe,
    output logic [IRQ_CNT-1:0]   irq_lvl
);
    line_sel_t             sel;
    line_ctl_t             wr_ctl;
    line_ctl_t             ctl [NUM_LINES];
    logic [NUM_LINES-1:0]  lvl;
    logic [DATA_W-1:0]     rd_next;

    pinbank_decode u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    pinbank_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (lvl)
    );

    assign wr_ctl = unpack_reg(bus_wdata);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic sel_me;
        assign sel_me = bus_we && sel.hit && (sel.idx == LINE_W'(i));

        pinbank_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (sel_me),
            .wr_ctl (wr_ctl),
            .ctl    (ctl[i]),
            .pad_o  (pad_out[i]),
            .pad_en (pad_oe[i])
        );
    end

    always_comb begin
        rd_next = '0;
        if (sel.hit) rd_next = pack_reg(lvl[sel.idx], ctl[sel.idx]);
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_next;
    end

    assign irq_lvl = lvl[IRQ_FIRST +: IRQ_CNT];

endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk
    import pinbank_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_we,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [IRQ_CNT-1:0]   irq_in,
    input logic [NUM_LINES-1:0] pad_out,
    input logic [NUM_LINES-1:0] pad_oe,
    input logic [IRQ_CNT-1:0]   irq_lvl
);
    line_sel_t         sel;
    logic              rd_hit_q;
    logic              rd_dis_q;
    logic              rd_val_q;
    logic              wr_q;
    logic [LINE_W-1:0] wr_idx_q;
    line_ctl_t         wr_ctl_q;
    logic [1:0]        cyc_q;

    assign sel = lookup(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_hit_q <= 1'b0;
            rd_dis_q <= 1'b0;
            rd_val_q <= 1'b0;
            wr_q     <= 1'b0;
            wr_idx_q <= '0;
            wr_ctl_q <= '0;
            cyc_q    <= '0;
        end else begin
            rd_hit_q <= sel.hit;
            rd_dis_q <= ~pad_oe[sel.idx];
            rd_val_q <= pad_out[sel.idx];
            wr_q     <= bus_we && sel.hit;
            wr_idx_q <= sel.idx;
            wr_ctl_q <= unpack_reg(bus_wdata);
            if (cyc_q != 2'd2) cyc_q <= cyc_q + 2'd1;
        end
    end

    p_reset_idle_r5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pad_oe == '0 && pad_out == '0));

    p_write_lands_r4: assert property (@(posedge clk) disable iff (rst)
        wr_q |-> (pad_oe[wr_idx_q] == ~wr_ctl_q.dis && pad_out[wr_idx_q] == wr_ctl_q.val));

    p_quiet_pads_r8: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && sel.hit) |=> ($stable(pad_oe) && $stable(pad_out)));

    p_hole_reads_zero_r6: assert property (@(posedge clk) disable iff (rst)
        !rd_hit_q |-> bus_rdata == '0);

    p_readback_r3: assert property (@(posedge clk) disable iff (rst)
        rd_hit_q |-> (bus_rdata[BIT_DIS] == rd_dis_q && bus_rdata[BIT_VAL] == rd_val_q));

    p_spare_bits_r7: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[7:6] == 2'b00 && bus_rdata[3:1] == 3'b000);

    p_irq_delay_r9: assert property (@(posedge clk) disable iff (rst)
        (cyc_q == 2'd2) |-> irq_lvl == $past(irq_in, 2));

endmodule

bind pinbank_ctrl pinbank_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_in    (pad_in[pinbank_pkg::IRQ_FIRST +: pinbank_pkg::IRQ_CNT]),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .irq_lvl   (irq_lvl)
);

// File: tb/pinbank_ctrl_test.sv
module pinbank_ctrl_test;
    import pinbank_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [ADDR_W-1:0]    bus_addr = '0;
    logic                 bus_we = 1'b0;
    logic [DATA_W-1:0]    bus_wdata = '0;
    logic [DATA_W-1:0]    bus_rdata;
    logic [NUM_LINES-1:0] pad_in = '0;
    logic [NUM_LINES-1:0] pad_out;
    logic [NUM_LINES-1:0] pad_oe;
    logic [IRQ_CNT-1:0]   irq_lvl;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_dis;
    logic [31:0] exp_val;

    int tb_base [5] = '{'h50, 'h88, 'h140, 'h188, 'h1c0};
    int tb_len  [5] = '{4, 16, 6, 2, 4};

    always #10 clk = ~clk;

    pinbank_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq_lvl   (irq_lvl)
    );

    function automatic int line_at(int a);
        int first;
        first = 0;
        if (a % 4 != 0) return -1;
        for (int g = 0; g < 5; g++) begin
            if (a >= tb_base[g] && a < tb_base[g] + 4 * tb_len[g])
                return first + (a - tb_base[g]) / 4;
            first += tb_len[g];
        end
        return -1;
    endfunction

    function automatic logic [7:0] exp_reg(int li);
        logic [7:0] r;
        r = 8'h00;
        if (li >= 0) begin
            r[0] = pad_in[li];
            r[4] = exp_val[li];
            r[5] = exp_dis[li];
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic rd(input int a, output logic [7:0] d);
        bus_addr = ADDR_W'(a);
        bus_we   = 1'b0;
        @(posedge clk);
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        bus_addr  = ADDR_W'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic sweep_reads(input string tag);
        logic [7:0] d;
        for (int a = 0; a < 512; a++) begin
            int li;
            li = line_at(a);
            rd(a, d);
            if (li < 0) chk({tag, " R6 hole read"}, 32'(d), 32'h0);
            else        chk({tag, " R1 R7 line read"}, 32'(d), 32'(exp_reg(li)));
        end
    endtask

    initial begin
        logic [7:0] d;
        logic [7:0] held;
        logic [IRQ_CNT-1:0] prev_irq;

        exp_dis = '1;
        exp_val = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R5: reset state at the pads
        chk("R5 pad_oe after reset", pad_oe, 32'h0);
        chk("R5 pad_out after reset", pad_out, 32'h0);

        // R1 R5 R6: full window read sweep
        sweep_reads("R5");

        // R3 R4 R7 R8: write each populated line, two polarity passes
        for (int pass = 0; pass < 2; pass++) begin
            for (int a = 0; a < 512; a += 4) begin
                int li;
                logic [7:0] w;
                li = line_at(a);
                if (li >= 0) begin
                    w    = 8'b1100_1011;
                    w[5] = ((li % 3) != 0) ^ pass[0];
                    w[4] = (li[1] ^ li[0]) ^ pass[0];
                    w[0] = pass[0];
                    wr(a, w);
                    exp_dis[li] = w[5];
                    exp_val[li] = w[4];
                    chk("R4 pad_oe after write", pad_oe, ~exp_dis);
                    chk("R3 R8 pad_out after write", pad_out, exp_val);
                end
            end
            sweep_reads("R4");
        end

        // R6: writes to holes and misaligned offsets leave every line alone
        for (int a = 0; a < 512; a++) begin
            if (line_at(a) < 0) begin
                wr(a, (a % 8 < 4) ? 8'hFF : 8'h00);
                chk("R6 pad_oe after hole write", pad_oe, ~exp_dis);
                chk("R6 pad_out after hole write", pad_out, exp_val);
            end
        end

        // R2 R7: synchronized input level in bit 0
        foreach (tb_len[p]) begin
            logic [31:0] pat;
            case (p)
                0: pat = 32'hA5A5_5A5A;
                1: pat = 32'hFFFF_FFFF;
                2: pat = 32'h1234_8765;
                3: pat = 32'h8000_0001;
                default: pat = 32'h0;
            endcase
            pad_in = pat;
            repeat (3) @(negedge clk);
            for (int a = 0; a < 512; a += 4) begin
                int li;
                li = line_at(a);
                if (li >= 0) begin
                    rd(a, d);
                    chk("R2 input level read", 32'(d), 32'(exp_reg(li)));
                end
            end
        end

        // R8: read data changes only at the clock edge after the address
        rd('h50, held);
        chk("R8 read of line 0", 32'(held), 32'(exp_reg(0)));
        bus_addr = '0;
        #3;
        chk("R8 rdata held before edge", 32'(bus_rdata), 32'(held));
        @(posedge clk);
        @(negedge clk);
        chk("R8 rdata after edge", 32'(bus_rdata), 32'h0);

        // R9: interrupt levels, two-edge delay, all 16 patterns
        prev_irq = pad_in[31:28];
        for (int v = 0; v < 16; v++) begin
            pad_in[31:28] = 4'(v);
            @(posedge clk);
            @(negedge clk);
            chk("R9 irq one edge after step", 32'(irq_lvl), 32'(prev_irq));
            @(posedge clk);
            @(negedge clk);
            chk("R9 irq two edges after step", 32'(irq_lvl), 32'(v));
            prev_irq = 4'(v);
        end

        // R5: reset in mid-run restores inputs-only state
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_dis = '1;
        exp_val = '0;
        chk("R5 pad_oe after second reset", pad_oe, 32'h0);
        chk("R5 pad_out after second reset", pad_out, 32'h0);
        repeat (3) @(negedge clk);
        rd('h1cc, d);
        chk("R5 line 31 after second reset", 32'(d), 32'(exp_reg(31)));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule